// File: doc/BRIEF.md
# Card Clock Divider with Init Burst

This block derives the clock that drives a memory card from the peripheral master clock. An 8-bit divisor N sets the card clock to the master clock divided by 2×(N+1). Each half period lasts exactly N+1 master cycles, so the duty cycle is 50%. The fastest setting is half the master clock and the slowest is the master clock over 512. A control write starts the clock or stops it, and a soft-reset bit returns the block to its power-up state.

Before the first real command, software requests a fixed burst of 74 card clock cycles for card initialization. The request is a command-register write whose 3-bit special-operation field carries code 1. The command-ready flag drops while the burst runs and rises when the 74th cycle ends. The flag is visible on a pin and at bit 0 of a status word on a registered read port.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the card clock is low, the clock-enable indication is 0, command-ready is 1 and the divisor is 0, so enabling gives phases of one master cycle.
- R2: While enabled, every high phase and every low phase of the card clock lasts N+1 master cycles, where N is the divisor in bits 7:0 of the word written at offset 0x04.
- R3: A write to offset 0x00 with bit 0 set turns the clock on, and one with bit 1 set turns it off. When both bits are set, off wins.
- R4: While turned off, the card clock is low by the second master cycle after the off write and stays low.
- R5: A new divisor takes effect at the next falling edge of the card clock. The new length first appears on a low phase, and every phase is either the old length or the new one.
- R6: A write to offset 0x14 whose bits 10:8 equal 1, made while the clock is on, clears command-ready in the cycle after the write. Exactly 74 rising card clock edges follow, and command-ready returns to 1 on the same edge at which the card clock falls to end the 74th cycle.
- R7: An init request is ignored while the clock is off, when bits 10:8 hold any code other than 1, and while a burst is already running (a second request does not lengthen it).
- R8: A divisor written during a burst does not change the burst's phases. The new value applies from the first falling edge after the burst ends.
- R9: Turning the clock off during a burst ends the burst, and command-ready returns to 1 in the cycle after the write.
- R10: A write to offset 0x00 with bit 7 set resets the divisor to 0, turns the clock off and sets command-ready to 1, even during a burst.
- R11: The read port returns command-ready in bit 0 when the address is 0x40, and zero for any other address, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Status read offset |
| rd_data | output | DATA_W | Registered read data |
| card_clk | output | 1 | Divided card clock |
| clk_on | output | 1 | Clock-enable indication |
| cmd_ready | output | 1 | Command-ready flag, low during the init burst |

## Verification
The divisor sweep covers every value from 0 to 15 and adds 100 and 255. This separates a period of 2×(N+1) from off-by-one variants such as N or 2N+1, and it exercises the full width of the counter. A divisor change made mid-run shows whether the new value is picked up at the falling edge and not within a phase. Init bursts are run in several ways: plain, with a repeated request, with a divisor write part-way through, aborted by the off bit, and aborted by soft reset. Counting the rising edges of each burst and the length of each of its phases separates a correct 74-cycle burst at the old rate from bursts that are restarted, retimed or left hanging.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  // register byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_CMD  = 'h14;
  localparam int OFF_STAT = 'h40;

  // control word bits
  localparam int CTRL_ON_BIT   = 0;
  localparam int CTRL_OFF_BIT  = 1;
  localparam int CTRL_SRST_BIT = 7;

  // special-operation field of the command word
  localparam int SPC_LSB  = 8;
  localparam int SPC_W    = 3;
  localparam int SPC_INIT = 1;

  // status word bits
  localparam int STAT_READY_BIT = 0;
endpackage

// File: rtl/card_clk_regs.sv
module card_clk_regs
  import card_clk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              init_req,
  output logic              stop_req
);
  logic hit_ctrl, hit_mode, hit_cmd, soft_rst;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
  assign hit_mode = wr_en && (wr_addr == ADDR_W'(OFF_MODE));
  assign hit_cmd  = wr_en && (wr_addr == ADDR_W'(OFF_CMD));
  assign soft_rst = hit_ctrl && wr_data[CTRL_SRST_BIT];

  assign init_req = hit_cmd && (wr_data[SPC_LSB +: SPC_W] == SPC_W'(SPC_INIT));
  assign stop_req = hit_ctrl && (wr_data[CTRL_OFF_BIT] || soft_rst);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else begin
      if (hit_ctrl) begin
        if (wr_data[CTRL_OFF_BIT])
          en_q <= 1'b0;
        else if (wr_data[CTRL_ON_BIT])
          en_q <= 1'b1;
      end
      if (hit_mode)
        div_q <= wr_data[DIV_W-1:0];
    end
  end

  // off must win over on in the same write
  assert_off_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_ctrl && wr_data[CTRL_OFF_BIT]) |=> !en_q);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hold_i,
  output logic             card_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act;
  logic             wrap;

  assign wrap   = run_i && (cnt == '0);
  assign rise_o = wrap && !card_clk_o;
  assign fall_o = wrap && card_clk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      act        <= '0;
      card_clk_o <= 1'b0;
    end else if (!run_i) begin
      card_clk_o <= 1'b0;
      cnt        <= div_i;
      act        <= div_i;
    end else if (wrap) begin
      card_clk_o <= ~card_clk_o;
      if (card_clk_o && !hold_i) begin
        act <= div_i;
        cnt <= div_i;
      end else begin
        cnt <= act;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_off_low_R4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !card_clk_o);

  assert_rate_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_i) && $past(run_i)) |-> $stable(act));
endmodule

// File: rtl/card_clk_burst.sv
module card_clk_burst #(
  parameter int BURST_CYCLES = 74
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BURST_CYCLES + 1);

  logic [CNT_W-1:0] n_rise;

  always_ff @(posedge clk) begin
    if (rst || abort_i || !en_i) begin
      busy_o <= 1'b0;
      n_rise <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        n_rise <= '0;
      end
    end else begin
      if (rise_i)
        n_rise <= n_rise + 1'b1;
      if (fall_i && n_rise == CNT_W'(BURST_CYCLES))
        busy_o <= 1'b0;
    end
  end

  assert_busy_needs_clock_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> en_i);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (n_rise <= CNT_W'(BURST_CYCLES)));

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && en_i) |-> ($past(fall_i) && $past(n_rise) == CNT_W'(BURST_CYCLES)));

  assert_start_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && en_i && !busy_o && !abort_i) |=> busy_o);
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int DIV_W        = 8,
  parameter int BURST_CYCLES = 74
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              card_clk,
  output logic              clk_on,
  output logic              cmd_ready
);
  logic             en_q, init_req, stop_req, busy, rise, fall;
  logic [DIV_W-1:0] div_q;

  card_clk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .div_q(div_q), .init_req(init_req), .stop_req(stop_req)
  );

  card_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run_i(en_q), .div_i(div_q), .hold_i(busy),
    .card_clk_o(card_clk), .rise_o(rise), .fall_o(fall)
  );

  card_clk_burst #(.BURST_CYCLES(BURST_CYCLES)) u_burst (
    .clk(clk), .rst(rst), .en_i(en_q), .start_i(init_req), .abort_i(stop_req),
    .rise_i(rise), .fall_i(fall), .busy_o(busy)
  );

  assign clk_on    = en_q;
  assign cmd_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr == ADDR_W'(OFF_STAT))
      rd_data <= DATA_W'(cmd_ready) << STAT_READY_BIT;
    else
      rd_data <= '0;
  end

  assert_ready_drops_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_ready) |-> $past(init_req) && $past(clk_on));
endmodule

// File: tb/card_clk_gen_tb.sv
module card_clk_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        card_clk, clk_on, cmd_ready;
  int          checks = 0;
  int          errors = 0;

  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_CMD = 8'h14, A_STAT = 8'h40;

  card_clk_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .card_clk(card_clk), .clk_on(clk_on),
    .cmd_ready(cmd_ready)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic seg(output int len);
    logic v;
    v = card_clk;
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (card_clk == v && len < 3000);
  endtask

  task automatic phases(input int exp, input string tag);
    int len, bad, last;
    bad = 0; last = 0;
    seg(len);
    for (int k = 0; k < 4; k++) begin
      seg(len);
      if (len != exp) begin bad++; last = len; end
    end
    chk(bad == 0, tag, last, exp);
  endtask

  task automatic burst_run(input int inj_at, input logic [7:0] ia, input logic [31:0] id,
                           input int exp_seg, output int rises, output int badseg,
                           output int end_ok);
    logic prev;
    int   run, i;
    bit   first;
    prev = card_clk; run = 0; first = 1'b1; rises = 0; badseg = 0; end_ok = 0; i = 0;
    while (!cmd_ready && i < 100000) begin
      if (i == inj_at) begin
        wr_en = 1'b1; wr_addr = ia; wr_data = id;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      i++;
      if (card_clk != prev) begin
        if (!prev) rises++;
        if (!first && run != exp_seg) badseg++;
        first = 1'b0;
        run = 1;
      end else begin
        run++;
      end
      if (cmd_ready) end_ok = (card_clk == 1'b0 && prev == 1'b1) ? 1 : 0;
      prev = card_clk;
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int len, r, b, e, hi;
    int segs[8];
    logic vals[8];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(card_clk == 1'b0, "R1 card_clk low", card_clk, 0);
    chk(clk_on == 1'b0, "R1 clk_on off", clk_on, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready set", cmd_ready, 1);
    rd_addr = A_STAT;
    @(negedge clk);
    chk(rd_data == 32'd1, "R11 status after reset", rd_data, 1);
    wr(A_CTRL, 32'h1);
    chk(clk_on == 1'b1, "R3 on bit", clk_on, 1);
    phases(1, "R1 default divisor gives one-cycle phases");

    // R2 sweep
    for (int i = 0; i < 18; i++) begin
      int n;
      n = (i < 16) ? i : ((i == 16) ? 100 : 255);
      wr(A_CTRL, 32'h2);
      wr(A_MODE, n);
      wr(A_CTRL, 32'h1);
      phases(n + 1, $sformatf("R2 phase length N=%0d", n));
    end

    // R4 off holds clock low
    wr(A_CTRL, 32'h2);
    @(negedge clk);
    chk(clk_on == 1'b0, "R3 off bit", clk_on, 0);
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      if (card_clk) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R4 clock low while off", hi, 0);

    // R3 both bits: off wins
    wr(A_CTRL, 32'h3);
    chk(clk_on == 1'b0, "R3 off wins over on", clk_on, 0);

    // R5 divisor change mid-run
    wr(A_MODE, 2);
    wr(A_CTRL, 32'h1);
    seg(len); seg(len);
    wr(A_MODE, 6);
    seg(len);
    for (int k = 0; k < 8; k++) begin
      vals[k] = card_clk;
      seg(segs[k]);
    end
    b = 0; e = -1;
    for (int k = 0; k < 8; k++) begin
      if (segs[k] != 3 && segs[k] != 7) b++;
      if (segs[k] == 7 && e < 0) e = k;
    end
    chk(b == 0, "R5 no phase of foreign length", b, 0);
    chk(segs[7] == 7, "R5 new length reached", segs[7], 7);
    chk(e >= 0 && vals[e] == 1'b0, "R5 new length starts on low phase", (e >= 0) ? vals[e] : 9, 0);

    // R6 plain burst at N=1
    wr(A_CTRL, 32'h2);
    wr(A_MODE, 1);
    wr(A_CTRL, 32'h1);
    repeat (7) @(negedge clk);
    wr(A_CMD, 32'h100);
    chk(cmd_ready == 1'b0, "R6 ready cleared after init write", cmd_ready, 0);
    burst_run(-1, 8'h0, 32'h0, 2, r, b, e);
    chk(r == 74, "R6 rising edges in burst", r, 74);
    chk(b == 0, "R6 burst phase lengths", b, 0);
    chk(e == 1, "R6 ready returns on final falling edge", e, 1);
    @(negedge clk);
    chk(rd_data == 32'd1, "R11 status after burst", rd_data, 1);

    // R7 repeated request does not lengthen
    wr(A_CMD, 32'h100);
    burst_run(20, A_CMD, 32'h100, 2, r, b, e);
    chk(r == 74, "R7 second request ignored during burst", r, 74);

    // R7 request while off
    wr(A_CTRL, 32'h2);
    wr(A_CMD, 32'h100);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (!cmd_ready || card_clk) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R7 request ignored while off", hi, 0);

    // R7 other special code
    wr(A_CTRL, 32'h1);
    wr(A_CMD, 32'h200);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (!cmd_ready) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R7 code 2 ignored", hi, 0);

    // R8 divisor write during burst
    wr(A_CMD, 32'h100);
    burst_run(10, A_MODE, 32'd5, 2, r, b, e);
    chk(r == 74 && b == 0, "R8 burst kept old rate", b, 0);
    for (int k = 0; k < 4; k++) seg(segs[k]);
    chk(segs[0] == 2 && segs[1] == 2, "R8 old rate until next fall", segs[1], 2);
    chk(segs[2] == 6 && segs[3] == 6, "R8 new rate after burst", segs[2], 6);

    // R9 abort by off
    wr(A_CTRL, 32'h2);
    wr(A_MODE, 3);
    wr(A_CTRL, 32'h1);
    wr(A_CMD, 32'h100);
    repeat (20) @(negedge clk);
    chk(cmd_ready == 1'b0 && rd_data == 32'd0, "R11 status low during burst", rd_data, 0);
    wr(A_CTRL, 32'h2);
    chk(cmd_ready == 1'b1, "R9 off aborts burst", cmd_ready, 1);
    @(negedge clk);
    chk(card_clk == 1'b0, "R4 clock low after abort", card_clk, 0);

    // R11 other address
    rd_addr = 8'h44;
    @(negedge clk);
    chk(rd_data == 32'd0, "R11 other address reads zero", rd_data, 0);
    rd_addr = A_STAT;
    @(negedge clk);
    chk(rd_data == 32'd1, "R11 status address reads ready", rd_data, 1);

    // R10 soft reset during burst
    wr(A_MODE, 9);
    wr(A_CTRL, 32'h1);
    wr(A_CMD, 32'h100);
    repeat (15) @(negedge clk);
    chk(cmd_ready == 1'b0, "R6 burst running before soft reset", cmd_ready, 0);
    wr(A_CTRL, 32'h80);
    chk(cmd_ready == 1'b1, "R10 soft reset sets ready", cmd_ready, 1);
    chk(clk_on == 1'b0, "R10 soft reset turns clock off", clk_on, 0);
    @(negedge clk);
    chk(card_clk == 1'b0, "R10 clock low after soft reset", card_clk, 0);
    wr(A_CTRL, 32'h1);
    phases(1, "R10 divisor back to zero");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule